// File: doc/BRIEF.md
# Programmable Flash Burst Read Sequencer

This block reads from an asynchronous parallel flash device on a peripheral bus. A requester presents a start address, a beat count and three wait-state values: first-access latency, per-beat latency and recovery gap. The block then drives the active-low chip-select, output-enable and write-enable strobes and a split address bus. It samples the 16-bit data bus after the programmed number of cycles and hands each sampled byte or word back with a single-cycle valid pulse.

One burst carries up to four beats. The upper address field stays fixed for the whole burst. Only the low three bits step, by one for byte access or by two for word access, and they wrap inside the aligned 8-byte window. The wait values are latched when the request is accepted, so the requester may change them afterwards. Each wait state lasts one interface clock. Typical settings are 4/4/1 for a 55 ns part, 8/4/4 for a 120 ns part and 12/4/4 for a 150 ns part.

Top module: `flash_burst_reader`

## Requirements
- R1: `req_ready` is high only in idle. A `req_valid` seen while a burst is in progress has no effect on the strobes, the address or the returned data. A new cycle starts only after a request is accepted in idle.
- R2: The beat count is clamped to the range 1..4. A request of 0 performs one beat, and a request of 5 to 7 performs four beats.
- R3: After acceptance there is exactly one address cycle (chip-select low, output-enable high). It is followed by `cfg_a2d_ws` wait cycles with output-enable low, then the first sample cycle. A value of zero puts the sample cycle directly after the address cycle.
- R4: Between consecutive sample cycles of one burst there are exactly `cfg_d2d_ws` wait cycles with both strobes low. A value of zero makes the sample cycles adjacent.
- R5: After the last sample cycle, chip-select and output-enable stay high for `cfg_rec_ws` cycles. In the cycle after that, `done` pulses for one cycle together with `req_ready`.
- R6: `flash_addr_hi` equals request address bits 24..3 and holds steady while chip-select is low.
- R7: `flash_addr_lo` starts at request address bits 2..0, with bit 0 cleared when `req_wide` is 1. It advances by 1 (byte) or 2 (word) in the cycle after each non-final sample and wraps modulo 8.
- R8: Output-enable is low only while chip-select is low. Write-enable stays high at all times.
- R9: `rd_valid` is high for exactly the cycle after each sample cycle. `rd_data` then holds the bus value present during that sample cycle.
- R10: After reset, chip-select, output-enable and write-enable are high, `req_ready` is high, and `rd_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | interface clock |
| rst | input | 1 | synchronous active-high reset |
| req_valid | input | 1 | read request strobe |
| req_addr | input | 25 | start byte address |
| req_beats | input | 3 | requested beat count (clamped to 1..4) |
| req_wide | input | 1 | 1 = 16-bit word beats, 0 = byte beats |
| cfg_a2d_ws | input | 4 | wait states from address to first sample |
| cfg_d2d_ws | input | 4 | wait states between later samples |
| cfg_rec_ws | input | 4 | recovery wait states after the last sample |
| req_ready | output | 1 | idle, request will be accepted |
| flash_addr_hi | output | 22 | address bits 24..3, fixed per burst |
| flash_addr_lo | output | 3 | address bits 2..0, stepping per beat |
| flash_ce_n | output | 1 | chip select, active low |
| flash_oe_n | output | 1 | output enable, active low |
| flash_we_n | output | 1 | write enable, active low, held high |
| flash_dq | input | 16 | flash data bus |
| rd_data | output | 16 | returned beat |
| rd_valid | output | 1 | one-cycle pulse per returned beat |
| done | output | 1 | one-cycle pulse when recovery ends |

## Verification
The assertions assume that `req_valid` is meaningful only against `req_ready`. They also assume `flash_dq` is stable during each sample cycle, so the value returned is the value the bench drove there. The bench drives the data bus as a fixed function of the address the block presents. It raises requests in idle only, except for a deliberate pulse in the middle of a burst, and that pulse is always dropped before the burst ends. The wait fields change from one request to the next and cover zero, the three reference speed profiles and mixed values.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
  localparam int MAX_BEATS = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT,
    ST_SAMPLE,
    ST_REC
  } seq_state_e;
endpackage

// File: rtl/ws_down_counter.sv
module ws_down_counter #(
  parameter int WS_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [WS_W-1:0] load_val,
  output logic            zero
);
  logic [WS_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val - 1'b1;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int LO_W   = 3,
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LO_W-1:0]   start_lo,
  input  logic              wide,
  input  logic [BEAT_W-1:0] beats,
  input  logic              step,
  output logic [LO_W-1:0]   lo,
  output logic              last
);
  logic              wide_q;
  logic [BEAT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo     <= '0;
      wide_q <= 1'b0;
      left   <= '0;
    end else if (load) begin
      lo     <= wide ? {start_lo[LO_W-1:1], 1'b0} : start_lo;
      wide_q <= wide;
      left   <= beats;
    end else if (step) begin
      lo     <= lo + (wide_q ? LO_W'(2) : LO_W'(1));
      left   <= left - 1'b1;
    end
  end

  assign last = (left == BEAT_W'(1));
endmodule

// File: rtl/flash_burst_reader.sv
module flash_burst_reader
  import flash_rd_pkg::*;
#(
  parameter int ADDR_W = 25,
  parameter int LO_W   = 3,
  parameter int DATA_W = 16,
  parameter int WS_W   = 4,
  parameter int BEAT_W = 3,
  localparam int HI_W  = ADDR_W - LO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BEAT_W-1:0] req_beats,
  input  logic              req_wide,
  input  logic [WS_W-1:0]   cfg_a2d_ws,
  input  logic [WS_W-1:0]   cfg_d2d_ws,
  input  logic [WS_W-1:0]   cfg_rec_ws,
  output logic              req_ready,
  output logic [HI_W-1:0]   flash_addr_hi,
  output logic [LO_W-1:0]   flash_addr_lo,
  output logic              flash_ce_n,
  output logic              flash_oe_n,
  output logic              flash_we_n,
  input  logic [DATA_W-1:0] flash_dq,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              done
);
  seq_state_e      state, nxt;
  logic [WS_W-1:0] a2d_q, d2d_q, rec_q;
  logic            cnt_load, cnt_zero;
  logic [WS_W-1:0] cnt_val;
  logic            ag_load, ag_step, ag_last;
  logic [BEAT_W-1:0] beats_eff;

  always_comb begin
    if (req_beats == '0)                      beats_eff = BEAT_W'(1);
    else if (int'(req_beats) > MAX_BEATS)     beats_eff = BEAT_W'(MAX_BEATS);
    else                                      beats_eff = req_beats;
  end

  ws_down_counter #(.WS_W(WS_W)) u_wait (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
  );

  burst_addr_gen #(.LO_W(LO_W), .BEAT_W(BEAT_W)) u_addr (
    .clk(clk), .rst(rst), .load(ag_load), .start_lo(req_addr[LO_W-1:0]),
    .wide(req_wide), .beats(beats_eff), .step(ag_step),
    .lo(flash_addr_lo), .last(ag_last)
  );

  always_comb begin
    nxt      = state;
    cnt_load = 1'b0;
    cnt_val  = a2d_q;
    ag_load  = 1'b0;
    ag_step  = 1'b0;
    case (state)
      ST_IDLE: if (req_valid) begin
        nxt     = ST_ADDR;
        ag_load = 1'b1;
      end
      ST_ADDR: if (a2d_q == '0) nxt = ST_SAMPLE;
               else begin nxt = ST_WAIT; cnt_load = 1'b1; cnt_val = a2d_q; end
      ST_WAIT: if (cnt_zero) nxt = ST_SAMPLE;
      ST_SAMPLE: begin
        if (ag_last) begin
          if (rec_q == '0) nxt = ST_IDLE;
          else begin nxt = ST_REC; cnt_load = 1'b1; cnt_val = rec_q; end
        end else begin
          ag_step = 1'b1;
          if (d2d_q == '0) nxt = ST_SAMPLE;
          else begin nxt = ST_WAIT; cnt_load = 1'b1; cnt_val = d2d_q; end
        end
      end
      ST_REC:  if (cnt_zero) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      flash_ce_n    <= 1'b1;
      flash_oe_n    <= 1'b1;
      req_ready     <= 1'b1;
      rd_valid      <= 1'b0;
      rd_data       <= '0;
      done          <= 1'b0;
      flash_addr_hi <= '0;
      a2d_q         <= '0;
      d2d_q         <= '0;
      rec_q         <= '0;
    end else begin
      state      <= nxt;
      flash_ce_n <= !(nxt == ST_ADDR || nxt == ST_WAIT || nxt == ST_SAMPLE);
      flash_oe_n <= !(nxt == ST_WAIT || nxt == ST_SAMPLE);
      req_ready  <= (nxt == ST_IDLE);
      rd_valid   <= (state == ST_SAMPLE);
      done       <= (state != ST_IDLE) && (nxt == ST_IDLE);
      if (state == ST_SAMPLE) rd_data <= flash_dq;
      if (ag_load) begin
        flash_addr_hi <= req_addr[ADDR_W-1:LO_W];
        a2d_q         <= cfg_a2d_ws;
        d2d_q         <= cfg_d2d_ws;
        rec_q         <= cfg_rec_ws;
      end
    end
  end

  assign flash_we_n = 1'b1;
endmodule

// File: rtl/flash_burst_reader_chk.sv
module flash_burst_reader_chk #(
  parameter int HI_W = 22
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic [HI_W-1:0] flash_addr_hi,
  input logic            flash_ce_n,
  input logic            flash_oe_n,
  input logic            rd_valid,
  input logic            done
);
  // R8
  oe_needs_ce_chk: assert property (@(posedge clk) disable iff (rst)
    !flash_oe_n |-> !flash_ce_n);

  // R6
  addr_hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!flash_ce_n && $past(!flash_ce_n)) |-> $stable(flash_addr_hi));

  // R9
  valid_after_oe_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(!flash_oe_n));

  // R1
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !flash_ce_n |-> !req_ready);

  // R1
  start_needs_accept_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flash_ce_n) |-> $past(req_valid && req_ready));

  // R5
  done_in_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (req_ready && flash_ce_n && flash_oe_n));
endmodule

bind flash_burst_reader flash_burst_reader_chk #(.HI_W(HI_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .flash_addr_hi(flash_addr_hi), .flash_ce_n(flash_ce_n),
  .flash_oe_n(flash_oe_n), .rd_valid(rd_valid), .done(done)
);

// File: tb/flash_burst_reader_test.sv
`timescale 1ns/1ps
module flash_burst_reader_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [24:0] req_addr = '0;
  logic [2:0]  req_beats = '0;
  logic        req_wide = 1'b0;
  logic [3:0]  cfg_a2d_ws = '0, cfg_d2d_ws = '0, cfg_rec_ws = '0;
  logic        req_ready;
  logic [21:0] flash_addr_hi;
  logic [2:0]  flash_addr_lo;
  logic        flash_ce_n, flash_oe_n, flash_we_n;
  logic [15:0] flash_dq;
  logic [15:0] rd_data;
  logic        rd_valid, done;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] bus_val(input logic [21:0] hi, input logic [2:0] lo);
    return {hi[12:0], lo} ^ 16'h5A3C;
  endfunction

  assign flash_dq = bus_val(flash_addr_hi, flash_addr_lo);

  flash_burst_reader uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_beats(req_beats), .req_wide(req_wide), .cfg_a2d_ws(cfg_a2d_ws),
    .cfg_d2d_ws(cfg_d2d_ws), .cfg_rec_ws(cfg_rec_ws), .req_ready(req_ready),
    .flash_addr_hi(flash_addr_hi), .flash_addr_lo(flash_addr_lo),
    .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n),
    .flash_dq(flash_dq), .rd_data(rd_data), .rd_valid(rd_valid), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at t=%0t: actual=%0h expected=%0h", tag, what, $time, act, exp);
    end
  endtask

  task automatic idle_check(input string tag);
    chk(flash_ce_n == 1'b1, tag, "ce_n idle", int'(flash_ce_n), 1);
    chk(flash_oe_n == 1'b1, tag, "oe_n idle", int'(flash_oe_n), 1);
    chk(flash_we_n == 1'b1, "R8", "we_n idle", int'(flash_we_n), 1);
    chk(req_ready == 1'b1, tag, "ready idle", int'(req_ready), 1);
    chk(rd_valid == 1'b0, tag, "valid idle", int'(rd_valid), 0);
    chk(done == 1'b0, tag, "done idle", int'(done), 0);
  endtask

  // Phase codes of the reference schedule: 0 done/idle, 1 address, 2 wait, 3 sample, 4 recovery
  task automatic run_burst(input logic [24:0] a, input int nreq, input bit wide,
                           input int a2d, input int d2d, input int rec, input bit poke);
    int ph[$];
    int nb;
    int cur_lo, last_lo, step;
    bit act;
    nb   = (nreq == 0) ? 1 : (nreq > 4) ? 4 : nreq;  // R2
    step = wide ? 2 : 1;
    cur_lo = wide ? (int'(a[2:0]) & 6) : int'(a[2:0]);
    last_lo = 0;
    ph.push_back(1);
    repeat (a2d) ph.push_back(2);
    ph.push_back(3);
    for (int b = 1; b < nb; b++) begin
      repeat (d2d) ph.push_back(2);
      ph.push_back(3);
    end
    repeat (rec) ph.push_back(4);
    ph.push_back(0);

    req_addr = a; req_beats = 3'(nreq); req_wide = wide;
    cfg_a2d_ws = 4'(a2d); cfg_d2d_ws = 4'(d2d); cfg_rec_ws = 4'(rec);
    req_valid = 1'b1;
    for (int i = 0; i < ph.size(); i++) begin
      @(negedge clk);
      if (i == 0) begin
        req_valid = 1'b0;
        cfg_a2d_ws = 4'd15; cfg_d2d_ws = 4'd15; cfg_rec_ws = 4'd15;
      end
      if (poke && i == 2) begin
        req_valid = 1'b1; req_addr = 25'h1FFFFFF; req_beats = 3'd4; req_wide = ~wide;  // R1
      end
      if (poke && i == 3) req_valid = 1'b0;
      act = (ph[i] == 1 || ph[i] == 2 || ph[i] == 3);
      chk(flash_ce_n == !act, (ph[i] == 4) ? "R5" : "R3", "ce_n", int'(flash_ce_n), int'(!act));
      chk(flash_oe_n == !(ph[i] == 2 || ph[i] == 3), (ph[i] == 2 && i > a2d) ? "R4" : "R3",
          "oe_n", int'(flash_oe_n), int'(!(ph[i] == 2 || ph[i] == 3)));
      chk(flash_we_n == 1'b1, "R8", "we_n", int'(flash_we_n), 1);
      chk(req_ready == (ph[i] == 0), "R1", "ready", int'(req_ready), int'(ph[i] == 0));
      chk(done == (ph[i] == 0), "R5", "done", int'(done), int'(ph[i] == 0));
      chk(rd_valid == (i > 0 && ph[i-1] == 3), "R9", "rd_valid", int'(rd_valid),
          int'(i > 0 && ph[i-1] == 3));
      if (act) begin
        chk(flash_addr_hi == a[24:3], "R6", "addr_hi", int'(flash_addr_hi), int'(a[24:3]));
        chk(int'(flash_addr_lo) == cur_lo, "R7", "addr_lo", int'(flash_addr_lo), cur_lo);
      end
      if (rd_valid && i > 0 && ph[i-1] == 3)
        chk(rd_data == bus_val(a[24:3], 3'(last_lo)), "R9", "rd_data", int'(rd_data),
            int'(bus_val(a[24:3], 3'(last_lo))));
      if (ph[i] == 3) begin
        last_lo = cur_lo;
        cur_lo  = (cur_lo + step) % 8;
      end
    end
    @(negedge clk);
    idle_check("R5");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    idle_check("R10");
    // R3 R4 R5: 120 ns profile, two byte beats
    run_burst(25'h0123458, 2, 1'b0, 8, 4, 4, 1'b0);
    // R7: 55 ns profile, four word beats, odd start aligned and wrapping
    run_burst(25'h0ABCDE3, 4, 1'b1, 4, 4, 1, 1'b0);
    // R7: 150 ns profile, three byte beats wrapping from 6
    run_burst(25'h1F00006, 3, 1'b0, 12, 4, 4, 1'b0);
    // R3 R4 R5: all wait fields zero
    run_burst(25'h0000000, 4, 1'b0, 0, 0, 0, 1'b0);
    // R2: zero beats clamps to one, seven clamps to four
    run_burst(25'h0555551, 0, 1'b0, 2, 1, 2, 1'b0);
    run_burst(25'h0555555, 7, 1'b1, 1, 3, 0, 1'b0);
    // R1: request pulse during a burst is ignored
    run_burst(25'h1234567, 3, 1'b0, 8, 2, 3, 1'b1);
    // R3: single word, zero recovery
    run_burst(25'h00FF00F, 1, 1'b1, 0, 2, 0, 1'b0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule